// File: doc/BRIEF.md
# Packed SIMD Averaging Unit

This block is one execution slot of a wide vector pipeline. Each cycle it can accept one 32-bit instruction word and two vector operands. If the word is one of sixteen averaging operations, it returns the lane-wise mean of the two operands. Lanes can be 8, 16, 32 or 64 bits wide. Each operation treats lanes as either signed or unsigned, and either truncates toward minus infinity or rounds half up. Each lane is computed at its own width: both operands are halved first, and the dropped low bits are added back as a one-bit correction. The sum is therefore never wider than the lane.

The result, the destination register index and two flags appear one clock after the input strobe. The flags are a valid flag and a not-handled flag. The register file, hazard logic and all other vector operations sit outside this block.

Top module: `vec_avg_unit`

## Requirements
- R1: Instruction encoding. An accepted word is an averaging operation only when bits [31:20] equal 12'h746 and the selector in bits [19:15] has its top two bits equal to 01 or 10. Any other word sets out_illegal with the result. An averaging word clears out_illegal.
- R2: A word that is not an averaging operation gives an all-zero out_result.
- R3: Selector bits [16:15] pick the lane width: 00 gives 8 bits (32 lanes), 01 gives 16 bits, 10 gives 32 bits and 11 gives 64 bits (4 lanes).
- R4: Selector bit 17 = 0 with selector bit 19 = 0 is a signed truncating average. Each lane is floor((a+b)/2), with lanes read as two's complement.
- R5: Selector bit 17 = 0 with selector bit 19 = 1 is a signed rounding average. Each lane is floor((a+b+1)/2).
- R6: Selector bit 17 = 1 gives the unsigned form of the same two averages. Lanes are read as unsigned, and bit 19 still chooses rounding.
- R7: out_valid is high in exactly the cycles that follow a cycle in which in_valid was high.
- R8: out_dest carries bits [4:0] of the word accepted in the previous cycle.
- R9: While rst_n is low at a clock edge, the following cycle shows out_valid low.
- R10: Each result lane depends only on the same lane of both sources. No carry passes between lanes.
- R11: Averaging a value with itself returns that value in every mode. This covers the most negative signed value and unsigned all-ones, where the average must not overflow. In signed mode, -1 averaged with 0 gives -1 when truncating and 0 when rounding.
- R12: In a cycle with in_valid low, out_result, out_dest and out_illegal keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input strobe: instr, src_a and src_b are accepted |
| instr | input | 32 | Instruction word |
| src_a | input | 256 | First source vector (register field bits [9:5]) |
| src_b | input | 256 | Second source vector (register field bits [14:10]) |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 256 | Lane-wise average, or zero when not handled |
| out_dest | output | 5 | Destination register index |
| out_illegal | output | 1 | Word was not an averaging operation |

## Verification
The assertions assume that in_valid, instr and both sources are settled at each rising edge. They also assume that the register fields bits [14:5] only name the sources and have no effect on the data. The self-average property relies on the two sources being equal in the same cycle as the strobe. The stimulus therefore drives every input at the falling edge. It also forces equal operands in a share of the random vectors, and it mixes random words from outside the opcode map with legal ones.

// File: rtl/vavg_pkg.sv
`timescale 1ns/1ps
package vavg_pkg;
   // fixed major opcode of the averaging group, bits [31:20]
   localparam logic [11:0] AVG_MAJOR = 12'h746;
   localparam int          NUM_SIZES = 4;
   localparam int          REG_W     = 5;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DBL  = 2'd3
   } lane_sz_e;

   typedef struct packed {
      logic     hit;   // word belongs to the averaging group
      logic     uns;   // unsigned lanes
      logic     rnd;   // round half up instead of truncating
      lane_sz_e sz;
   } avg_op_t;
endpackage

// File: rtl/vavg_decode.sv
`timescale 1ns/1ps
module vavg_decode
   import vavg_pkg::*;
(
   input  logic [31:0]      instr,
   output avg_op_t          op,
   output logic [REG_W-1:0] dest
);
   logic [4:0] sel;
   logic       grp;

   assign sel  = instr[19:15];
   assign grp  = (instr[31:20] == AVG_MAJOR);
   assign dest = instr[REG_W-1:0];

   always_comb begin
      op.hit = grp && ((sel[4:3] == 2'b01) || (sel[4:3] == 2'b10));
      op.uns = sel[2];
      op.rnd = sel[4];
      op.sz  = lane_sz_e'(sel[1:0]);
   end

   // source register fields name operands only; data arrives on ports
   logic unused_src_fields;
   assign unused_src_fields = ^instr[14:5];
endmodule

// File: rtl/vavg_lane.sv
`timescale 1ns/1ps
module vavg_lane #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         uns,
   input  logic         rnd,
   output logic [W-1:0] y
);
   if (W < 2) begin : g_bad_w
      $error("vavg_lane: W must be at least 2");
   end

   logic [W-1:0] half_a;
   logic [W-1:0] half_b;
   logic         fix;

   // halve first, then restore the dropped low bits: no wider sum needed
   assign half_a = {(uns ? 1'b0 : a[W-1]), a[W-1:1]};
   assign half_b = {(uns ? 1'b0 : b[W-1]), b[W-1:1]};
   assign fix    = rnd ? (a[0] | b[0]) : (a[0] & b[0]);
   assign y      = half_a + half_b + W'(fix);
endmodule

// File: rtl/vavg_lanes.sv
`timescale 1ns/1ps
module vavg_lanes
   import vavg_pkg::*;
#(
   parameter int VLEN = 256
) (
   input  logic [VLEN-1:0] a,
   input  logic [VLEN-1:0] b,
   input  avg_op_t         op,
   output logic [VLEN-1:0] y
);
   logic [VLEN-1:0] per_size [NUM_SIZES];

   for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
      localparam int LW = 8 << k;
      localparam int NL = VLEN / LW;
      logic [VLEN-1:0] y_k;

      for (genvar i = 0; i < NL; i++) begin : g_lane
         vavg_lane #(.W(LW)) u_lane (
            .a   (a[i*LW +: LW]),
            .b   (b[i*LW +: LW]),
            .uns (op.uns),
            .rnd (op.rnd),
            .y   (y_k[i*LW +: LW])
         );
      end
      assign per_size[k] = y_k;
   end

   always_comb begin
      y = '0;
      if (op.hit) y = per_size[op.sz];
   end
endmodule

// File: rtl/vec_avg_unit.sv
`timescale 1ns/1ps
module vec_avg_unit
   import vavg_pkg::*;
#(
   parameter int VLEN = 256
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [31:0]     instr,
   input  logic [VLEN-1:0] src_a,
   input  logic [VLEN-1:0] src_b,
   output logic            out_valid,
   output logic [VLEN-1:0] out_result,
   output logic [4:0]      out_dest,
   output logic            out_illegal
);
   if ((VLEN < 64) || (VLEN % 64 != 0)) begin : g_bad_vlen
      $error("vec_avg_unit: VLEN must be a positive multiple of 64");
   end

   avg_op_t          op;
   logic [REG_W-1:0] dest_d;
   logic [VLEN-1:0]  avg_d;

   vavg_decode u_dec (
      .instr (instr),
      .op    (op),
      .dest  (dest_d)
   );

   vavg_lanes #(.VLEN(VLEN)) u_lanes (
      .a  (src_a),
      .b  (src_b),
      .op (op),
      .y  (avg_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_dest    <= '0;
         out_illegal <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result  <= avg_d;
            out_dest    <= dest_d;
            out_illegal <= !op.hit;
         end
      end
   end
endmodule

// File: rtl/vec_avg_unit_chk.sv
`timescale 1ns/1ps
module vec_avg_unit_chk #(
   parameter int VLEN = 256
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [31:0]     instr,
   input logic [VLEN-1:0] src_a,
   input logic [VLEN-1:0] src_b,
   input logic            out_valid,
   input logic [VLEN-1:0] out_result,
   input logic [4:0]      out_dest,
   input logic            out_illegal
);
   logic unused_chk_bits;
   assign unused_chk_bits = ^instr[17:5] ^ ^src_b;

   p_foreign_major_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (instr[31:20] != 12'h746) |=> out_illegal);

   p_known_group_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (instr[31:20] == 12'h746) && (instr[19:18] == 2'b01) |=> !out_illegal);

   p_zero_when_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_illegal |-> (out_result == '0));

   p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_dest == $past(instr[4:0])));

   p_reset_r9: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

   p_self_average_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (src_a == src_b) |=> out_illegal || (out_result == $past(src_a)));

   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result) && $stable(out_dest) && $stable(out_illegal));
endmodule

bind vec_avg_unit vec_avg_unit_chk #(.VLEN(VLEN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .instr       (instr),
   .src_a       (src_a),
   .src_b       (src_b),
   .out_valid   (out_valid),
   .out_result  (out_result),
   .out_dest    (out_dest),
   .out_illegal (out_illegal)
);

// File: tb/tb_vec_avg_unit.sv
`timescale 1ns/1ps
module tb_vec_avg_unit;
   localparam int VLEN = 256;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [31:0]     instr = '0;
   logic [VLEN-1:0] src_a = '0;
   logic [VLEN-1:0] src_b = '0;
   logic            out_valid;
   logic [VLEN-1:0] out_result;
   logic [4:0]      out_dest;
   logic            out_illegal;

   int nchk = 0;
   int nfail = 0;
   logic [VLEN-1:0] last_res = '0;
   logic [4:0]      last_dest = '0;
   logic            last_ill = 1'b0;

   always #10 clk = ~clk;

   vec_avg_unit #(.VLEN(VLEN)) dut (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .instr (instr),
      .src_a (src_a), .src_b (src_b), .out_valid (out_valid),
      .out_result (out_result), .out_dest (out_dest), .out_illegal (out_illegal)
   );

   function automatic logic [31:0] mk(input logic [4:0] sel, input logic [4:0] rd);
      return {12'h746, sel, 5'd3, 5'd7, rd};
   endfunction

   function automatic bit is_avg(input logic [31:0] w);
      return (w[31:20] == 12'h746) && (w[19:18] == 2'b01 || w[19:18] == 2'b10);
   endfunction

   // reference: widen each lane, add, shift; independent of the halving trick
   function automatic logic [VLEN-1:0] model(input logic [31:0] w,
                                              input logic [VLEN-1:0] a,
                                              input logic [VLEN-1:0] b);
      logic [VLEN-1:0] res = '0;
      int   lw = 8 << w[16:15];
      bit   uns = w[17];
      bit   rnd = w[19];
      logic [63:0] mask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
      if (!is_avg(w)) return '0;
      for (int i = 0; i < VLEN / lw; i++) begin
         logic [VLEN-1:0] ta;
         logic [VLEN-1:0] tb_;
         logic [63:0] xa;
         logic [63:0] xb;
         logic signed [65:0] ea;
         logic signed [65:0] eb;
         logic signed [65:0] s;
         ta  = a >> (i * lw);
         tb_ = b >> (i * lw);
         xa  = ta[63:0] & mask;
         xb  = tb_[63:0] & mask;
         if (!uns && xa[lw-1]) xa = xa | ~mask;
         if (!uns && xb[lw-1]) xb = xb | ~mask;
         ea = uns ? {2'b00, xa} : {{2{xa[63]}}, xa};
         eb = uns ? {2'b00, xb} : {{2{xb[63]}}, xb};
         s  = ea + eb + (rnd ? 66'sd1 : 66'sd0);
         s  = s >>> 1;
         res = res | ((VLEN'(s[63:0] & mask)) << (i * lw));
      end
      return res;
   endfunction

   function automatic string mode_tag(input logic [31:0] w);
      if (!is_avg(w)) return "R2";
      if (w[17]) return "R6";
      return w[19] ? "R5" : "R4";
   endfunction

   task automatic chk1(input bit ok, input string tag, input string what,
                       input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic run_vec(input logic [31:0] w, input logic [VLEN-1:0] a,
                          input logic [VLEN-1:0] b, input string tag_in);
      logic [VLEN-1:0] exp;
      string tag;
      tag = (tag_in == "") ? mode_tag(w) : tag_in;
      exp = model(w, a, b);
      @(negedge clk);
      in_valid = 1'b1; instr = w; src_a = a; src_b = b;
      @(negedge clk);
      in_valid = 1'b0;
      chk1(out_valid === 1'b1, "R7", "valid", VLEN'(out_valid), VLEN'(1));
      chk1(out_illegal === !is_avg(w), "R1", "illegal flag",
           VLEN'(out_illegal), VLEN'(!is_avg(w)));
      chk1(out_dest === w[4:0], "R8", "dest", VLEN'(out_dest), VLEN'(w[4:0]));
      chk1(out_result === exp, tag, "result (R3 lane size)", out_result, exp);
      last_res = exp; last_dest = w[4:0]; last_ill = !is_avg(w);
   endtask

   task automatic idle_chk();
      @(negedge clk);
      in_valid = 1'b0;
      instr = $urandom; src_a = {8{$urandom}}; src_b = {8{$urandom}};
      @(negedge clk);
      chk1(out_valid === 1'b0, "R7", "valid while idle", VLEN'(out_valid), '0);
      chk1(out_result === last_res && out_dest === last_dest && out_illegal === last_ill,
           "R12", "hold", out_result, last_res);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      logic [VLEN-1:0] pat_a;
      logic [VLEN-1:0] pat_b;
      void'($urandom(32'h5eed_1234));
      // reset with a strobe present: R9
      in_valid = 1'b1; instr = mk(5'b01000, 5'd9);
      repeat (3) @(negedge clk);
      chk1(out_valid === 1'b0, "R9", "valid in reset", VLEN'(out_valid), '0);
      chk1(out_result === '0, "R9", "result in reset", out_result, '0);
      in_valid = 1'b0;
      rst_n = 1'b1;

      // R11 corners
      run_vec(mk(5'b01000, 5'd1), {32{8'h80}}, {32{8'h80}}, "R11");
      run_vec(mk(5'b10011, 5'd2), {4{64'h8000_0000_0000_0000}},
              {4{64'h8000_0000_0000_0000}}, "R11");
      run_vec(mk(5'b01000, 5'd3), '1, '0, "R11");   // -1 trunc -> -1
      run_vec(mk(5'b10000, 5'd4), '1, '0, "R11");   // -1 round -> 0
      chk1(out_result === '0, "R11", "-1 with 0 rounds to 0", out_result, '0);
      run_vec(mk(5'b01100, 5'd5), '1, '1, "R11");   // unsigned all-ones
      chk1(out_result === '1, "R11", "unsigned all-ones kept", out_result, '1);
      run_vec(mk(5'b10111, 5'd6), '1, '1, "R11");
      // R10: every byte carries out, neighbours must not see it
      run_vec(mk(5'b10100, 5'd7), '1, {32{8'h01}}, "R10");
      chk1(out_result === {32{8'h80}}, "R10", "byte isolation", out_result, {32{8'h80}});
      // R3: one operand pair across all four sizes, both signednesses
      pat_a = {8{32'h8765_F00D}}; pat_b = {8{32'h7F01_0FF3}};
      for (int s = 0; s < 4; s++) begin
         run_vec(mk({3'b010, 2'(s)}, 5'(s)), pat_a, pat_b, "R3");
         run_vec(mk({3'b101, 2'(s)}, 5'(s + 8)), pat_a, pat_b, "R3");
      end
      // R1 / R2: foreign words
      run_vec({12'h746, 5'b00111, 15'h1234}, '1, '1, "R2");
      run_vec({12'h746, 5'b11000, 15'h0042}, '1, 0, "R2");
      run_vec({12'h747, 5'b01000, 15'h0011}, '1, 0, "R2");
      idle_chk();

      // constrained random
      for (int n = 0; n < 500; n++) begin
         logic [31:0] w;
         logic [4:0]  sel;
         sel = {($urandom % 2 == 0) ? 2'b01 : 2'b10, 3'($urandom)};
         w = {12'h746, sel, 15'($urandom)};
         if ($urandom % 8 == 0) w = $urandom;
         for (int k = 0; k < VLEN / 32; k++) begin
            pat_a[k*32 +: 32] = $urandom;
            pat_b[k*32 +: 32] = $urandom;
         end
         if ($urandom % 6 == 0) pat_b = pat_a;
         run_vec(w, pat_a, pat_b, "");
         if ($urandom % 10 == 0) idle_chk();
      end
      idle_chk();

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule